// File: doc/BRIEF.md
# Floating-Point Conditional Compare Unit

This block performs a scalar floating-point compare that depends on a condition. It takes two operands on 64-bit buses, a precision selector, a 4-bit condition code, a 4-bit immediate flag pattern and the current NZCV flags. The block first tests the condition against the current flags. If the condition passes, it compares the first operand with the second and encodes the IEEE-754 ordering relation as new NZCV flags. If the condition fails, the immediate pattern becomes the new flags. No comparison result is used in that case.

The compare is quiet. A quiet NaN only produces an unordered result. A signaling NaN also raises an Invalid Operation flag. The result is registered, and it appears one cycle after a valid strobe together with an output valid pulse. The execution pipeline places the unit after operand read and forwards its flag result into the processor state. Trap checks and exception delivery stay outside the block.

Top module: `fpcc_unit`

## Requirements
- R1: When the condition passes, `res_nzcv` carries the result of comparing `src_a` with `src_b`.
- R2: When the condition fails, `res_nzcv` equals `imm_flags`: N is taken from bit 3, Z from bit 2, C from bit 1 and V from bit 0.
- R3: The `fmt` selector gives the operand format. 2'b11 is half precision (5-bit exponent, 10-bit fraction). 2'b00 is single precision (8/23). 2'b01 is double precision (11/52). The reserved code 2'b10 is handled as double precision.
- R4: The comparison result is encoded as follows: equal gives 4'b0110, less gives 4'b1000, greater gives 4'b0010, and unordered gives 4'b0011. Unordered means that at least one operand is a NaN. A NaN has an all-ones exponent and a nonzero fraction.
- R5: `res_invalid` is 1 only when the condition passes and at least one operand is a signaling NaN. A signaling NaN is a NaN whose fraction MSB is 0. A quiet NaN gives the unordered result with `res_invalid` = 0.
- R6: +0 and -0 compare as equal, in any order.
- R7: Subnormal operands (exponent field 0) are compared by their exact values, with no flush to zero. Infinities order beyond every finite value.
- R8: The condition code is decoded on `cur_flags` as follows. 0000 passes on Z=1 and 0001 on Z=0. 0010 passes on C=1 and 0011 on C=0. 0100 passes on N=1 and 0101 on N=0. 0110 passes on V=1 and 0111 on V=0. 1000 passes on C=1 and Z=0, and 1001 passes when that is false. 1010 passes on N==V and 1011 on N!=V. 1100 passes on Z=0 and N==V, and 1101 passes when that is false. 1110 and 1111 always pass.
- R9: For half and single precision, only the low 16 or 32 bits of each operand bus are used. The upper bits have no effect on any output.
- R10: `res_invalid` is 0 whenever the condition fails, even if an operand is a signaling NaN.
- R11: The outputs update on the rising edge at which `in_valid` is 1, and `res_valid` is 1 in the following cycle only. While `in_valid` is 0, `res_nzcv` and `res_invalid` hold their values. After reset, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: operands and controls are valid |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| fmt | input | 2 | Precision selector |
| cond_code | input | 4 | Condition tested on `cur_flags` |
| imm_flags | input | 4 | Flags loaded when the condition fails |
| cur_flags | input | 4 | Current NZCV flags |
| res_valid | output | 1 | Result valid pulse |
| res_nzcv | output | 4 | New NZCV flags |
| res_invalid | output | 1 | Invalid Operation flag |

## Verification
Every result of this block, the flags, the invalid flag and the valid pulse, passes through one register stage. Each is therefore due exactly one rising edge after the edge that captured the strobe. The bench drives inputs on a falling edge and raises `in_valid` for one cycle. It compares all three outputs at the next falling edge, which is half a cycle after the capturing edge. The hold behaviour is checked one cycle later still, after a cycle with `in_valid` low and changed inputs.

// File: rtl/fpcc_pkg.sv
// Package: shared types and constants for the conditional FP compare unit.
// Assumes the widest supported format is 64-bit IEEE-754 double precision.
package fpcc_pkg;

    localparam int MAG_W = 63;  // exponent + fraction bits of the widest format

    typedef enum logic [1:0] {
        FMT_SINGLE = 2'b00,
        FMT_DOUBLE = 2'b01,
        FMT_RSVD   = 2'b10,
        FMT_HALF   = 2'b11
    } fmt_e;

    // Classified operand, independent of the source format.
    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;     // {exponent, fraction}, zero-extended
        logic             is_nan;
        logic             is_snan;
        logic             is_zero;
    } fp_class_t;

    localparam logic [3:0] FLAGS_EQ = 4'b0110;
    localparam logic [3:0] FLAGS_LT = 4'b1000;
    localparam logic [3:0] FLAGS_GT = 4'b0010;
    localparam logic [3:0] FLAGS_UN = 4'b0011;

endpackage

// File: rtl/fpcc_unpack.sv
// Module: fpcc_unpack
// Splits one operand bus into sign, magnitude and NaN/zero class for the
// selected format. Assumes the narrow formats sit in the low bits of the bus.
// The reserved format code is treated as double precision.
module fpcc_unpack
    import fpcc_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int HALF_EXP   = 5,
    parameter int HALF_MAN   = 10,
    parameter int SINGLE_EXP = 8,
    parameter int SINGLE_MAN = 23,
    parameter int DOUBLE_EXP = 11,
    parameter int DOUBLE_MAN = 52
) (
    input  logic [DATA_W-1:0] word,
    input  fmt_e              fmt,
    output fp_class_t         cls
);

    localparam int NUM_FMT = 3;

    fp_class_t [NUM_FMT-1:0] fmt_cls;

    // One classifier per format. Index 0 is half, 1 is single and 2 is double.
    for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
        localparam int EW = (g == 0) ? HALF_EXP : (g == 1) ? SINGLE_EXP : DOUBLE_EXP;
        localparam int MW = (g == 0) ? HALF_MAN : (g == 1) ? SINGLE_MAN : DOUBLE_MAN;

        logic          sgn;
        logic [EW-1:0] ex;
        logic [MW-1:0] mn;
        logic          nan;

        assign sgn = word[EW+MW];
        assign ex  = word[EW+MW-1:MW];
        assign mn  = word[MW-1:0];
        assign nan = (&ex) && (|mn);
        assign fmt_cls[g] = {sgn, MAG_W'({ex, mn}), nan, nan && !mn[MW-1], ~|{ex, mn}};
    end

    // Select the classifier that matches the requested format.
    always_comb begin
        unique case (fmt)
            FMT_HALF:   cls = fmt_cls[0];
            FMT_SINGLE: cls = fmt_cls[1];
            default:    cls = fmt_cls[2];
        endcase
    end

endmodule

// File: rtl/fpcc_compare.sv
// Module: fpcc_compare
// Quiet ordered compare of two classified operands, encoded as NZCV.
// Assumes both operands come from the same format, so the magnitudes are
// directly comparable as unsigned integers (subnormals included).
module fpcc_compare
    import fpcc_pkg::*;
(
    input  fp_class_t  opa,
    input  fp_class_t  opb,
    output logic [3:0] cmp_flags,
    output logic       cmp_invalid
);

    logic a_mag_larger;

    assign a_mag_larger = opa.mag > opb.mag;

    // Resolve the ordering relation and the signaling-NaN flag.
    always_comb begin
        cmp_invalid = opa.is_snan || opb.is_snan;
        if (opa.is_nan || opb.is_nan) begin
            cmp_flags = FLAGS_UN;
        end else if (opa.is_zero && opb.is_zero) begin
            cmp_flags = FLAGS_EQ;
        end else if (opa.sign != opb.sign) begin
            cmp_flags = opa.sign ? FLAGS_LT : FLAGS_GT;
        end else if (opa.mag == opb.mag) begin
            cmp_flags = FLAGS_EQ;
        end else begin
            cmp_flags = (a_mag_larger ^ opa.sign) ? FLAGS_GT : FLAGS_LT;
        end
    end

endmodule

// File: rtl/fpcc_cond.sv
// Module: fpcc_cond
// Evaluates a 4-bit condition code on the NZCV flags. The upper three bits
// pick the base test and the low bit inverts it. Codes 111x always pass.
module fpcc_cond (
    input  logic [3:0] cond_code,
    input  logic [3:0] flags,
    output logic       pass
);

    logic fn, fz, fc, fv;
    logic base;

    assign {fn, fz, fc, fv} = flags;

    // Base test selected by the upper code bits.
    always_comb begin
        unique case (cond_code[3:1])
            3'b000:  base = fz;
            3'b001:  base = fc;
            3'b010:  base = fn;
            3'b011:  base = fv;
            3'b100:  base = fc && !fz;
            3'b101:  base = (fn == fv);
            3'b110:  base = !fz && (fn == fv);
            default: base = 1'b1;
        endcase
    end

    // Apply the inversion bit, except for the always-pass pair.
    assign pass = (cond_code[3:1] == 3'b111) ? 1'b1 : (base ^ cond_code[0]);

endmodule

// File: rtl/fpcc_unit.sv
// Module: fpcc_unit (top)
// Conditional floating-point compare. It tests the condition on the current
// flags, compares the operands when the condition passes, and otherwise loads
// the immediate flags. The result is registered one cycle after in_valid.
// Assumes operands are already read from the register file.
module fpcc_unit
    import fpcc_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [1:0]        fmt,
    input  logic [3:0]        cond_code,
    input  logic [3:0]        imm_flags,
    input  logic [3:0]        cur_flags,
    output logic              res_valid,
    output logic [3:0]        res_nzcv,
    output logic              res_invalid
);

    localparam int NUM_OPS = 2;

    logic [NUM_OPS-1:0][DATA_W-1:0] op_bus;
    fp_class_t [NUM_OPS-1:0]        op_cls;
    logic [3:0]                     cmp_flags;
    logic                           cmp_invalid;
    logic                           cond_pass;

    assign op_bus[0] = src_a;
    assign op_bus[1] = src_b;

    // One unpacker per operand.
    for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
        fpcc_unpack #(.DATA_W(DATA_W)) u_unpack (
            .word (op_bus[k]),
            .fmt  (fmt_e'(fmt)),
            .cls  (op_cls[k])
        );
    end

    fpcc_compare u_compare (
        .opa         (op_cls[0]),
        .opb         (op_cls[1]),
        .cmp_flags   (cmp_flags),
        .cmp_invalid (cmp_invalid)
    );

    fpcc_cond u_cond (
        .cond_code (cond_code),
        .flags     (cur_flags),
        .pass      (cond_pass)
    );

    // Result register: capture the compare or the immediate on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_nzcv    <= 4'b0000;
            res_invalid <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                res_nzcv    <= cond_pass ? cmp_flags : imm_flags;
                res_invalid <= cond_pass && cmp_invalid;
            end
        end
    end

    // R11: a strobe yields a valid pulse in the next cycle only.
    assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    assert_valid_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_nzcv) && $stable(res_invalid)));

    // R2: a failed condition loads the immediate.
    assert_imm_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cond_pass) |=> (res_nzcv == $past(imm_flags)));

    // R10: no invalid flag without a comparison.
    assert_no_invalid_on_fail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cond_pass) |=> !res_invalid);

    // R5: an invalid flag only accompanies an unordered result.
    assert_invalid_unordered_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_invalid |-> (res_nzcv == FLAGS_UN));

    // R8: the always-pass codes never fail.
    assert_always_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_code[3:1] == 3'b111) |-> cond_pass);

    // R4: the compare yields exactly one of the four encodings.
    assert_flag_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (cmp_flags == FLAGS_EQ || cmp_flags == FLAGS_LT ||
                      cmp_flags == FLAGS_GT || cmp_flags == FLAGS_UN));

endmodule

// File: tb/fpcc_unit_test.sv
// Bench: condition sweep, operand pair sweep in every format code, and
// timing, reset and hold checks. The expected values come from real arithmetic.
module fpcc_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [1:0]  fmt = 2'b00;
    logic [3:0]  cond_code = 4'b0000;
    logic [3:0]  imm_flags = 4'b0000;
    logic [3:0]  cur_flags = 4'b0000;
    logic        res_valid;
    logic [3:0]  res_nzcv;
    logic        res_invalid;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    localparam logic [63:0] JUNK = 64'hC3A5_5A3C_F00F_9669;

    always #5 clk = ~clk;

    fpcc_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .fmt(fmt),
        .cond_code(cond_code), .imm_flags(imm_flags), .cur_flags(cur_flags),
        .res_valid(res_valid), .res_nzcv(res_nzcv), .res_invalid(res_invalid)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: R11 actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    function automatic int exp_w(int p);
        return (p == 3) ? 5 : (p == 0) ? 8 : 11;
    endfunction

    function automatic int man_w(int p);
        return (p == 3) ? 10 : (p == 0) ? 23 : 52;
    endfunction

    // Build test value number idx of format p, with junk in the unused upper bits.
    function automatic logic [63:0] mkval(int p, int idx);
        int ew = exp_w(p);
        int mw = man_w(p);
        longint unsigned eall = (64'd1 << ew) - 1;
        longint unsigned bias = (64'd1 << (ew - 1)) - 1;
        longint unsigned mmax = (64'd1 << mw) - 1;
        longint unsigned mhalf = 64'd1 << (mw - 1);
        longint unsigned s = 0, e = 0, m = 0;
        logic [63:0] w;
        case (idx)
            0:  begin s = 0; e = 0;        m = 0;     end
            1:  begin s = 1; e = 0;        m = 0;     end
            2:  begin s = 0; e = 0;        m = 1;     end
            3:  begin s = 1; e = 0;        m = 1;     end
            4:  begin s = 0; e = 0;        m = mmax;  end
            5:  begin s = 0; e = 1;        m = 0;     end
            6:  begin s = 0; e = bias;     m = 0;     end
            7:  begin s = 1; e = bias;     m = 0;     end
            8:  begin s = 0; e = bias;     m = mhalf; end
            9:  begin s = 0; e = eall - 1; m = mmax;  end
            10: begin s = 1; e = eall - 1; m = mmax;  end
            11: begin s = 0; e = eall;     m = 0;     end
            12: begin s = 1; e = eall;     m = 0;     end
            13: begin s = 0; e = eall;     m = mhalf; end
            14: begin s = 1; e = eall;     m = 1;     end
            default: begin s = 0; e = bias; m = 1; end
        endcase
        w = (s << (ew + mw)) | (e << mw) | m;
        if (ew + mw + 1 < 64)
            w = w | (JUNK & ~((64'd1 << (ew + mw + 1)) - 1));
        return w;
    endfunction

    function automatic bit is_nan_v(int p, logic [63:0] w, output bit sig);
        int ew = exp_w(p);
        int mw = man_w(p);
        longint unsigned m = w & ((64'd1 << mw) - 1);
        longint unsigned e = (w >> mw) & ((64'd1 << ew) - 1);
        sig = (m >> (mw - 1)) == 0;
        return (e == (64'd1 << ew) - 1) && (m != 0);
    endfunction

    function automatic real fval(int p, logic [63:0] w);
        int ew = exp_w(p);
        int mw = man_w(p);
        longint unsigned m = w & ((64'd1 << mw) - 1);
        longint unsigned e = (w >> mw) & ((64'd1 << ew) - 1);
        longint bias = (64'd1 << (ew - 1)) - 1;
        real v;
        if (p == 1 || p == 2) return $bitstoreal(w);
        if (e == (64'd1 << ew) - 1)
            v = $bitstoreal(64'h7FF0_0000_0000_0000);
        else if (e == 0)
            v = real'(m) * (2.0 ** real'(1 - bias - mw));
        else
            v = real'(m + (64'd1 << mw)) * (2.0 ** real'(longint'(e) - bias - mw));
        return w[ew + mw] ? -v : v;
    endfunction

    function automatic bit cond_ok(logic [3:0] c, logic [3:0] f);
        bit n = f[3], z = f[2], cy = f[1], v = f[0];
        case (c)
            4'b0000: return z;
            4'b0001: return !z;
            4'b0010: return cy;
            4'b0011: return !cy;
            4'b0100: return n;
            4'b0101: return !n;
            4'b0110: return v;
            4'b0111: return !v;
            4'b1000: return cy && !z;
            4'b1001: return !(cy && !z);
            4'b1010: return n == v;
            4'b1011: return n != v;
            4'b1100: return !z && (n == v);
            4'b1101: return !(!z && (n == v));
            default: return 1'b1;
        endcase
    endfunction

    // Apply one vector for one cycle and check the registered result.
    task automatic run(input logic [63:0] a, input logic [63:0] b, input logic [1:0] p,
                       input logic [3:0] c, input logic [3:0] imm, input logic [3:0] cur,
                       input logic [3:0] exp_f, input bit exp_i, input string tag);
        @(negedge clk);
        src_a = a; src_b = b; fmt = p;
        cond_code = c; imm_flags = imm; cur_flags = cur;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        checks = checks + 1;
        if (res_valid !== 1'b1 || res_nzcv !== exp_f || res_invalid !== exp_i) begin
            fails = fails + 1;
            $display("FAIL %s: actual valid=%b nzcv=%b inv=%b expected valid=1 nzcv=%b inv=%b",
                     tag, res_valid, res_nzcv, res_invalid, exp_f, exp_i);
        end
    endtask

    initial begin
        logic [63:0] one_s, two_s;

        repeat (3) @(negedge clk);
        // R11: reset state.
        checks = checks + 1;
        if (res_valid !== 1'b0 || res_nzcv !== 4'b0000 || res_invalid !== 1'b0) begin
            fails = fails + 1;
            $display("FAIL R11 reset: actual valid=%b nzcv=%b inv=%b expected 0 0000 0",
                     res_valid, res_nzcv, res_invalid);
        end
        rst_n = 1'b1;

        // R8, R1 and R2: every condition code against every flag pattern.
        // 1.0 < 2.0 in single precision gives 1000. The immediate is 0101.
        one_s = 64'h0000_0000_3F80_0000;
        two_s = 64'h0000_0000_4000_0000;
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                if (cond_ok(4'(c), 4'(f)))
                    run(one_s, two_s, 2'b00, 4'(c), 4'b0101, 4'(f), 4'b1000, 1'b0, "R8 R1 pass");
                else
                    run(one_s, two_s, 2'b00, 4'(c), 4'b0101, 4'(f), 4'b0101, 1'b0, "R8 R2 fail");
            end
        end

        // R3, R4, R5, R6, R7 and R9: all value pairs in every format code.
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    logic [63:0] a = mkval(p, i);
                    logic [63:0] b = mkval(p, j);
                    bit sa, sb;
                    bit na = is_nan_v(p, a, sa);
                    bit nb = is_nan_v(p, b, sb);
                    logic [3:0] ef;
                    bit ei = (na && sa) || (nb && sb);
                    real ra, rb;
                    string tag;
                    if (na || nb) ef = 4'b0011;
                    else begin
                        ra = fval(p, a); rb = fval(p, b);
                        ef = (ra == rb) ? 4'b0110 : (ra < rb) ? 4'b1000 : 4'b0010;
                    end
                    if (ei) tag = "R5 snan";
                    else if (i < 2 && j < 2) tag = "R6 zeros";
                    else if ((i >= 2 && i <= 4) || (j >= 2 && j <= 4)) tag = "R7 subnormal";
                    else if (p == 2) tag = "R3 reserved fmt";
                    else if (p == 0 || p == 3) tag = "R9 narrow fmt";
                    else tag = "R4 double";
                    run(a, b, 2'(p), 4'b1110, 4'b1111, 4'b0000, ef, ei, tag);
                end
            end
        end

        // R10: a signaling NaN with a failing condition (EQ with Z=0).
        run(mkval(1, 14), mkval(1, 6), 2'b01, 4'b0000, 4'b1010, 4'b0000, 4'b1010, 1'b0, "R10 snan fail");
        // R5: a quiet NaN does not raise the invalid flag.
        run(mkval(3, 13), mkval(3, 13), 2'b11, 4'b1111, 4'b0000, 4'b0000, 4'b0011, 1'b0, "R5 qnan");
        // R9: the same half values with different junk above bit 15.
        run(64'hFFFF_FFFF_FFFF_3C00, 64'h0000_0000_0001_3C00, 2'b11, 4'b1110, 4'b0000, 4'b0000,
            4'b0110, 1'b0, "R9 upper bits");

        // R11: an idle cycle with changed inputs keeps the previous result.
        @(negedge clk);
        src_a = mkval(1, 14); imm_flags = 4'b1111; cond_code = 4'b0001;
        @(negedge clk);
        checks = checks + 1;
        if (res_valid !== 1'b0 || res_nzcv !== 4'b0110 || res_invalid !== 1'b0) begin
            fails = fails + 1;
            $display("FAIL R11 hold: actual valid=%b nzcv=%b inv=%b expected valid=0 nzcv=0110 inv=0",
                     res_valid, res_nzcv, res_invalid);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule